// File: doc/BRIEF.md
# Banked GPIO Expander Register File

This block is the device-side register bank of a GPIO expander with a parameterised number of pins. The pins are split into banks of eight. Each bank owns five byte registers: a direction register, a level register, an interrupt enable register, an interrupt status register and a general-purpose auxiliary byte. A host reaches them over a simple byte-wide read/write port that stands in for a serial byte-data front end.

The block drives pin output values and output enables. It samples the pin inputs through a two-flop synchroniser and latches a status bit whenever an enabled pin changes level. It also raises a single interrupt line toward the host, which the host treats as rising-edge sensitive. Direction bits can be hard-wired per pin through parameters. The host detects such pins by reading the direction register back after a write.

Top module: `gpx_regbank`

## Requirements
- R1: With SHIFT = log2(NUM_PINS) - 3 (NUM_PINS a power of two, at least 8), the address is {class, bank}: reg_addr[ADDR_W-1:SHIFT] selects the class (0 direction, 1 level, 2 interrupt enable, 3 interrupt status, 4 auxiliary) and the low SHIFT bits select the bank. Pin p is bit p%8 of bank p/8.
- R2: After reset, direction (apart from hard-wired bits), drive value, interrupt enable, status and auxiliary are 0 in every bank; irq and reg_rdata are 0.
- R3: A direction bit of 1 makes the pin an output and drives pin_oe high. Bits selected by DIR_FIX_MASK always hold DIR_FIX_VAL and ignore writes. A read-back returns the direction actually in effect.
- R4: A write to the level class sets the drive value on pin_out. A level read returns the drive value for output pins and the synchronised pin_in value for input pins.
- R5: A status bit sets when the synchronised level of its pin changes while its enable bit is 1. A pin whose enable is 0 never sets its status bit.
- R6: A read of a status register returns the pending bits and clears that bank's status. Writes to a status register are ignored. Status bits never drop without a read.
- R7: irq is high exactly while some status bit is set together with its enable bit.
- R8: Classes 5 to 7 read as 0 and ignore writes.
- R9: The auxiliary register of each bank stores and returns any written byte and has no effect on the pins.
- R10: reg_rdata presents the addressed register on the clock edge where reg_rd is sampled high, so the value is valid in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address {class, bank} |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| pin_in | input | NUM_PINS | Pin input levels, asynchronous |
| pin_out | output | NUM_PINS | Pin drive values |
| pin_oe | output | NUM_PINS | Pin output enables |
| irq | output | 1 | Interrupt request to the host |

## Verification
The bench writes all ones and all zeros to the bank that holds the hard-wired direction bits. A design that stored those bits as written would read back the raw value and drive a locked pin the wrong way. It toggles a pin whose enable is clear, and it writes zero to a pending status register. A design that latched disabled changes or let software clear status by writing would then show spurious or lost bits on the following read. It also writes to the unused classes and reads them back, to catch a decoder that aliases them onto real registers. Level reads on mixed input and output banks catch a design that returns the raw input instead of the drive value for outputs.

// File: rtl/gpx_pkg.sv
// Shared definitions for the banked GPIO expander register file.
// Assumes: register classes are encoded in three address bits above the bank index.
package gpx_pkg;
    typedef enum logic [2:0] {
        CLS_DIR = 3'd0,
        CLS_LVL = 3'd1,
        CLS_IEN = 3'd2,
        CLS_STS = 3'd3,
        CLS_AUX = 3'd4,
        CLS_RS5 = 3'd5,
        CLS_RS6 = 3'd6,
        CLS_RS7 = 3'd7
    } gpx_cls_e;
endpackage

// File: rtl/gpx_sync.sv
// Two-flop synchroniser for a vector of asynchronous pin inputs.
// Assumes: each bit is independent; a two-cycle latency is acceptable.
module gpx_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Capture the raw inputs, then re-register them to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/gpx_bank.sv
// One 8-pin bank: direction, drive, enable, status and auxiliary bytes,
// plus change detection on the synchronised pin levels.
// Assumes: wr_en and rd_clr are already qualified for this bank.
module gpx_bank
    import gpx_pkg::*;
#(
    parameter logic [7:0] FIX_MASK = 8'h00,
    parameter logic [7:0] FIX_VAL  = 8'h00
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  gpx_cls_e  cls,
    input  logic [7:0] wdata,
    input  logic      rd_clr,
    input  logic [7:0] pin_sync,
    output logic [7:0] dir_o,
    output logic [7:0] drv_o,
    output logic [7:0] lvl_o,
    output logic [7:0] ien_o,
    output logic [7:0] sts_o,
    output logic [7:0] aux_o,
    output logic      irq_o
);
    localparam logic [7:0] FIX_ON = FIX_VAL & FIX_MASK;

    logic [7:0] dir_q, drv_q, ien_q, sts_q, aux_q, prev_q;
    logic [7:0] chg, hit;

    assign chg = pin_sync ^ prev_q;
    assign hit = chg & ien_q;

    // Host-writable configuration bytes; locked direction bits keep their value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= FIX_ON;
            drv_q <= '0;
            ien_q <= '0;
            aux_q <= '0;
        end else if (wr_en) begin
            case (cls)
                CLS_DIR: dir_q <= (wdata & ~FIX_MASK) | FIX_ON;
                CLS_LVL: drv_q <= wdata;
                CLS_IEN: ien_q <= wdata;
                CLS_AUX: aux_q <= wdata;
                default: ;
            endcase
        end
    end

    // Remember the last synchronised level and latch enabled changes into status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            sts_q  <= '0;
        end else begin
            prev_q <= pin_sync;
            sts_q  <= (rd_clr ? 8'h00 : sts_q) | hit;
        end
    end

    assign dir_o = dir_q;
    assign drv_o = drv_q;
    assign lvl_o = (dir_q & drv_q) | (~dir_q & pin_sync);
    assign ien_o = ien_q;
    assign sts_o = sts_q;
    assign aux_o = aux_q;
    assign irq_o = |(sts_q & ien_q);

    // R5: a newly set status bit must have been enabled in the cycle before.
    p_sts_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_q & ~$past(sts_q) & ~$past(ien_q)) == 8'h00));

    // R6: after a clearing read only fresh changes may remain.
    p_sts_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> ((sts_q & ~$past(chg)) == 8'h00));

    // R6: without a read, no pending bit is lost.
    p_sts_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> (($past(sts_q) & ~sts_q) == 8'h00));

    // R3: locked direction bits never leave their fixed value.
    p_dir_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q & FIX_MASK) == FIX_ON);
endmodule

// File: rtl/gpx_regbank.sv
// Top of the banked GPIO expander register file: address decode, per-bank
// register instances, synchroniser, registered read-back and interrupt output.
// Assumes: NUM_PINS is a power of two and at least 8.
module gpx_regbank
    import gpx_pkg::*;
#(
    parameter int              NUM_PINS     = 16,
    parameter logic [NUM_PINS-1:0] DIR_FIX_MASK = 16'hC000,
    parameter logic [NUM_PINS-1:0] DIR_FIX_VAL  = 16'h4000,
    localparam int             SHIFT        = $clog2(NUM_PINS) - 3,
    localparam int             ADDR_W       = SHIFT + 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int NUM_BANKS = 1 << SHIFT;
    localparam int BANK_W    = (SHIFT > 0) ? SHIFT : 1;

    gpx_cls_e            cls;
    logic [BANK_W-1:0]   bank_sel;
    logic [NUM_PINS-1:0] pin_sync;
    logic [7:0]          dir_a [NUM_BANKS];
    logic [7:0]          drv_a [NUM_BANKS];
    logic [7:0]          lvl_a [NUM_BANKS];
    logic [7:0]          ien_a [NUM_BANKS];
    logic [7:0]          sts_a [NUM_BANKS];
    logic [7:0]          aux_a [NUM_BANKS];
    logic [NUM_BANKS-1:0] irq_a;
    logic [7:0]          rd_val;

    assign cls = gpx_cls_e'(reg_addr[ADDR_W-1:ADDR_W-3]);

    generate
        if (SHIFT > 0) begin : g_multi
            assign bank_sel = reg_addr[BANK_W-1:0];
        end else begin : g_single
            assign bank_sel = '0;
        end
    endgenerate

    gpx_sync #(.W(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pin_sync)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic hit_bank;
            assign hit_bank = (int'(bank_sel) == b);

            gpx_bank #(
                .FIX_MASK (DIR_FIX_MASK[b*8 +: 8]),
                .FIX_VAL  (DIR_FIX_VAL[b*8 +: 8])
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (reg_wr && hit_bank),
                .cls      (cls),
                .wdata    (reg_wdata),
                .rd_clr   (reg_rd && hit_bank && (cls == CLS_STS)),
                .pin_sync (pin_sync[b*8 +: 8]),
                .dir_o    (dir_a[b]),
                .drv_o    (drv_a[b]),
                .lvl_o    (lvl_a[b]),
                .ien_o    (ien_a[b]),
                .sts_o    (sts_a[b]),
                .aux_o    (aux_a[b]),
                .irq_o    (irq_a[b])
            );

            assign pin_oe[b*8 +: 8]  = dir_a[b];
            assign pin_out[b*8 +: 8] = drv_a[b];
        end
    endgenerate

    // Select the addressed register of the addressed bank; unused classes read 0.
    always_comb begin
        case (cls)
            CLS_DIR: rd_val = dir_a[bank_sel];
            CLS_LVL: rd_val = lvl_a[bank_sel];
            CLS_IEN: rd_val = ien_a[bank_sel];
            CLS_STS: rd_val = sts_a[bank_sel];
            CLS_AUX: rd_val = aux_a[bank_sel];
            default: rd_val = 8'h00;
        endcase
    end

    // Register the read data on the strobe edge and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= 8'h00;
        end else if (reg_rd) begin
            reg_rdata <= rd_val;
        end
    end

    assign irq = |irq_a;

    // R8: reads of unused classes return zero.
    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (cls > CLS_AUX)) |=> (reg_rdata == 8'h00));

    // R10: read data does not change without a read strobe.
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/gpx_regbank_tb.sv
`timescale 1ns/1ps
module gpx_regbank_tb;
    localparam int N = 16;
    localparam logic [N-1:0] FMASK = 16'hC000;
    localparam logic [N-1:0] FVAL  = 16'h4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out, pin_oe;
    logic irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [N-1:0] m_dir = FVAL & FMASK, m_drv = '0, m_ien = '0, m_sts = '0, m_aux = '0;
    logic [N-1:0] m_pins = '0;

    always #4 clk = ~clk;

    gpx_regbank #(.NUM_PINS(N), .DIR_FIX_MASK(FMASK), .DIR_FIX_VAL(FVAL)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected read value per R1, R4, R8.
    function automatic logic [7:0] exp_read(input logic [3:0] a);
        int b = int'(a[0]);
        logic [N-1:0] lvl = (m_dir & m_drv) | (~m_dir & m_pins);
        case (a[3:1])
            3'd0: return m_dir[b*8 +: 8];
            3'd1: return lvl[b*8 +: 8];
            3'd2: return m_ien[b*8 +: 8];
            3'd3: return m_sts[b*8 +: 8];
            3'd4: return m_aux[b*8 +: 8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        int b = int'(a[0]);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        case (a[3:1])
            3'd0: m_dir[b*8 +: 8] = (d & ~FMASK[b*8 +: 8]) | (FVAL[b*8 +: 8] & FMASK[b*8 +: 8]);
            3'd1: m_drv[b*8 +: 8] = d;
            3'd2: m_ien[b*8 +: 8] = d;
            3'd4: m_aux[b*8 +: 8] = d;
            default: ;
        endcase
    endtask

    // R10: value is sampled one cycle after the strobe.
    task automatic rd_chk(input string req, input logic [3:0] a);
        logic [7:0] e = exp_read(a);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        chk(req, {24'd0, reg_rdata}, {24'd0, e});
        if (a[3:1] == 3'd3) m_sts[int'(a[0])*8 +: 8] = 8'h00;
    endtask

    task automatic set_pins(input logic [N-1:0] v);
        @(negedge clk);
        pin_in = v;
        m_sts = m_sts | ((v ^ m_pins) & m_ien);
        m_pins = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_outs(input string req);
        chk(req, {16'd0, pin_oe}, {16'd0, m_dir});
        chk(req, {16'd0, pin_out}, {16'd0, m_drv});
        chk("R7 irq", {31'd0, irq}, {31'd0, |(m_sts & m_ien)});
    endtask

    initial begin
        void'($urandom(32'd4321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        chk("R2 rdata", {24'd0, reg_rdata}, 32'd0);
        chk_outs("R2 outputs");
        for (int a = 0; a < 10; a++) rd_chk("R2 reset regs", 4'(a));

        // R3: locked direction bits in bank 1 (bits 7:6 locked to 01)
        wr(4'd1, 8'hFF);
        rd_chk("R3 dir readback ones", 4'd1);
        chk("R3 dir value", {24'd0, m_dir[15:8]}, 32'h7F);
        wr(4'd1, 8'h00);
        rd_chk("R3 dir readback zeros", 4'd1);
        chk_outs("R3 oe");

        // R4: mixed bank 0, upper nibble outputs
        wr(4'd0, 8'hF0);
        wr(4'd2, 8'h00);
        wr(4'd2, 8'hA5);
        wr(4'd2, 8'h00);
        wr(4'd3 << 1, 8'h00);
        wr(4'd2 | 4'd0, 8'h00);
        wr(4'd1 << 1, 8'h3C);
        set_pins(16'h00C3);
        rd_chk("R4 level mixed", 4'd2);
        chk_outs("R4 pins");

        // R5: disabled pin change sets nothing
        set_pins(16'h00C2);
        rd_chk("R5 disabled no status", 4'd6);
        chk("R5 irq low", {31'd0, irq}, 32'd0);

        // R5/R6/R7: enabled change, status write ignored, read clears
        wr(4'd4, 8'h01);
        set_pins(16'h00C3);
        chk("R7 irq raised", {31'd0, irq}, 32'd1);
        wr(4'd6, 8'h00);
        rd_chk("R6 status write ignored", 4'd6);
        rd_chk("R6 status cleared", 4'd6);
        chk("R7 irq dropped", {31'd0, irq}, 32'd0);

        // R8: unused classes
        wr(4'd10, 8'hFF);
        wr(4'd15, 8'hFF);
        rd_chk("R8 unmapped 10", 4'd10);
        rd_chk("R8 unmapped 15", 4'd15);

        // R9: auxiliary bytes
        wr(4'd8, 8'hA5);
        wr(4'd9, 8'h5A);
        rd_chk("R9 aux bank0", 4'd8);
        rd_chk("R9 aux bank1", 4'd9);
        chk_outs("R9 no pin effect");

        // R1: random mix across all addresses
        for (int i = 0; i < 400; i++) begin
            int op = int'($urandom % 4);
            logic [3:0] a = 4'($urandom);
            case (op)
                0: wr(a, 8'($urandom));
                1: rd_chk("R1 random read", a);
                2: set_pins(16'($urandom));
                default: chk_outs("R1 random outputs");
            endcase
        end
        for (int a = 0; a < 16; a++) rd_chk("R1 final sweep", 4'(a));

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R10 watchdog actual=hung expected=complete");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule